// File: doc/BRIEF.md
# SD Host Command Issue Register Block

This block is the register-mapped command front end of an SD-card host controller. Software first loads a 32-bit argument, then writes a command word holding a 6-bit command index and a set of flags. Setting the start bit of that word launches the command. A small sequencer passes the index and argument to a command-line serialiser through a request/acknowledge handshake. It then waits for the card's response, for a response timeout, and for the card to release busy.

Completion is visible in the command word itself. The start bit reads back as 1 while the command is in flight and drops to 0 when it ends. A separate fail bit reports an error. Responses land in four 32-bit response words. A host status word collects the busy-release event and the command error causes, and software clears those bits by writing 1 to them. The serialiser and its CRC7 check sit outside the block. The serialiser returns the response bits with an error flag, and the SD clock appears only as a one-cycle tick strobe used for counting the timeout.

Top module: `sdh_cmd_regs`

## Requirements
- R1: After reset, every readable word (command 0x00, argument 0x04, timeout 0x08, response words 0x10 to 0x1C, status 0x20) reads 0 and ser_req is low.
- R2: The argument (0x04) and the timeout limit (0x08) are full 32-bit read/write words. An accepted write to the command word stores bits 11, 10, 9, 7, 6 and 5:0 and reads them back at the same positions; bits 13, 12 and 8 read 0.
- R3: An accepted write to the command word with bit 15 set starts a command. Bit 15 reads 1 until the command ends and 0 afterwards. ser_req stays high with ser_index = bits 5:0 and ser_arg = the argument until ser_ack is seen.
- R4: A write to the command word while bit 15 reads 1 is ignored: index and flags keep their values and no second command starts.
- R5: With bit 10 (no response) set, the command ends in the cycle the serialiser acknowledges it, without waiting for a response.
- R6: A short response (bit 9 clear) stores rsp_data[31:0] in word 0x10 only; words 0x14 to 0x1C keep their old values.
- R7: A long response (bit 9 set) stores rsp_data[31:0] at 0x10, [63:32] at 0x14, [95:64] at 0x18 and [127:96] at 0x1C.
- R8: If no response arrives before the timeout-limit count of sd_tick strobes, the command ends with status bit 6 (command timeout) and command bit 14 (fail) set.
- R9: A response flagged with rsp_crc_err ends the command with status bit 4 (CRC7 error) and command bit 14 set. The response word is still stored.
- R10: With bit 11 (busy wait) set, after a good response the command stays active while card_busy is high. It ends in the cycle card_busy is seen low, and status bit 10 (busy released) is set.
- R11: Status bits 10:3 clear when written with 1, and a 0 leaves them unchanged. Other status bits read 0 in this block.
- R12: An accepted write to the command word clears the fail bit, so a newly started command reads bit 14 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for both the write and the read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ser_req | output | 1 | Command ready for the serialiser |
| ser_index | output | 6 | Command index to send |
| ser_arg | output | 32 | Command argument to send |
| ser_rsp_none | output | 1 | Command expects no response |
| ser_rsp_long | output | 1 | Command expects a 136-bit response |
| ser_ack | input | 1 | Serialiser accepted the command |
| rsp_valid | input | 1 | Response received, one-cycle strobe |
| rsp_data | input | 128 | Response payload |
| rsp_crc_err | input | 1 | Response failed its CRC7 check |
| sd_tick | input | 1 | One strobe per SD clock, used for the timeout |
| card_busy | input | 1 | Card holds the data line busy |

## Verification
A register write takes effect at the first rising edge that samples the strobe, so the bench reads back at the following falling edge. A command ends one edge after its cause: the acknowledge for a command with no response, the response strobe, the tick that uses up the timeout count, or the first cycle card_busy is low. The start bit, fail bit, status bits and response words are therefore all sampled at the falling edge after that cause. Before each final event the bench also reads the start bit and confirms it is still 1.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  // command word bit positions (decoded by software)
  localparam int CMD_START = 15;
  localparam int CMD_FAIL  = 14;
  localparam int CMD_BUSYW = 11;
  localparam int CMD_NORSP = 10;
  localparam int CMD_LONG  = 9;
  localparam logic [13:0] CMD_KEEP_MASK = 14'h0EFF;

  // host status bit positions
  localparam int ST_W      = 11;
  localparam int ST_BUSY   = 10;
  localparam int ST_CTOUT  = 6;
  localparam int ST_CRC7   = 4;
  localparam int ST_CLR_LO = 3;
  localparam int ST_CLR_HI = 10;

  // word indices (byte address / 4)
  localparam int WI_CMD  = 0;
  localparam int WI_ARG  = 1;
  localparam int WI_TOUT = 2;
  localparam int WI_RSP0 = 4;
  localparam int WI_STS  = 8;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SEND, SQ_RESP, SQ_BUSY} sq_state_e;
endpackage

// File: rtl/sdh_cmd_seq.sv
module sdh_cmd_seq
  import sdh_pkg::*;
#(
  parameter int TOUT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              no_rsp,
  input  logic              busy_wait,
  input  logic [TOUT_W-1:0] tout_lim,
  input  logic              ser_ack,
  input  logic              rsp_valid,
  input  logic              rsp_crc_err,
  input  logic              sd_tick,
  input  logic              card_busy,
  output logic              ser_req,
  output logic              finish,
  output logic              set_fail,
  output logic              set_tout,
  output logic              set_crc7,
  output logic              set_busy,
  output logic              load_rsp
);
  sq_state_e         state_q, state_d;
  logic [TOUT_W-1:0] cnt_q, cnt_d;
  logic              expire;

  // timeout fires on the tick that brings the count to the limit
  assign expire  = sd_tick && (({1'b0, cnt_q} + (TOUT_W+1)'(1)) >= {1'b0, tout_lim});
  assign ser_req = (state_q == SQ_SEND);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    finish   = 1'b0;
    set_fail = 1'b0;
    set_tout = 1'b0;
    set_crc7 = 1'b0;
    set_busy = 1'b0;
    load_rsp = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (launch) state_d = SQ_SEND;
      SQ_SEND: begin
        if (ser_ack) begin
          if (no_rsp) begin
            finish  = 1'b1;
            state_d = SQ_IDLE;
          end else begin
            cnt_d   = '0;
            state_d = SQ_RESP;
          end
        end
      end
      SQ_RESP: begin
        if (rsp_valid) begin
          load_rsp = 1'b1;
          if (rsp_crc_err) begin
            finish   = 1'b1;
            set_fail = 1'b1;
            set_crc7 = 1'b1;
            state_d  = SQ_IDLE;
          end else if (busy_wait) begin
            state_d = SQ_BUSY;
          end else begin
            finish  = 1'b1;
            state_d = SQ_IDLE;
          end
        end else if (expire) begin
          finish   = 1'b1;
          set_fail = 1'b1;
          set_tout = 1'b1;
          state_d  = SQ_IDLE;
        end else if (sd_tick) begin
          cnt_d = cnt_q + TOUT_W'(1);
        end
      end
      SQ_BUSY: begin
        if (!card_busy) begin
          finish   = 1'b1;
          set_busy = 1'b1;
          state_d  = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/sdh_w1c_status.sv
module sdh_w1c_status #(
  parameter int W      = 11,
  parameter int CLR_LO = 3,
  parameter int CLR_HI = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] sts
);
  logic unused_clr;
  assign unused_clr = ^clr_bits;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b >= CLR_LO && b <= CLR_HI) begin : g_w1c
      logic bit_q, bit_d;
      // a new event wins over a clear in the same cycle
      always_comb bit_d = set_vec[b] | (bit_q & ~(clr_en & clr_bits[b]));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign sts[b] = bit_q;
    end else begin : g_live
      assign sts[b] = set_vec[b];
    end
  end
endmodule

// File: rtl/sdh_rsp_store.sv
module sdh_rsp_store #(
  parameter int NWORDS = 4,
  parameter int WW     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 long_rsp,
  input  logic [NWORDS*WW-1:0] rsp_in,
  output logic [NWORDS*WW-1:0] words
);
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic          en;
    logic [WW-1:0] word_q;
    assign en = load && ((w == 0) || long_rsp);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (en) word_q <= rsp_in[w*WW +: WW];
    end
    assign words[w*WW +: WW] = word_q;
  end
endmodule

// File: rtl/sdh_cmd_regs.sv
module sdh_cmd_regs
  import sdh_pkg::*;
#(
  parameter int AW     = 8,
  parameter int TOUT_W = 32,
  parameter int NWORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ser_req,
  output logic [5:0]        ser_index,
  output logic [31:0]       ser_arg,
  output logic              ser_rsp_none,
  output logic              ser_rsp_long,
  input  logic              ser_ack,
  input  logic              rsp_valid,
  input  logic [NWORDS*32-1:0] rsp_data,
  input  logic              rsp_crc_err,
  input  logic              sd_tick,
  input  logic              card_busy
);
  localparam int IW = AW - 2;

  logic [1:0]          rst_sync_q;
  logic                rst_n_s;
  logic [IW-1:0]       widx;
  logic [1:0]          unused_lsb;
  logic                cmd_wr, launch, arg_en, tout_en, sts_clr;
  logic                cmd_new, cmd_new_d, cmd_fail, cmd_fail_d;
  logic [13:0]         cmd_bits, cmd_bits_d;
  logic [31:0]         arg_q;
  logic [TOUT_W-1:0]   tout_q;
  logic                finish, set_fail, set_tout, set_crc7, set_busy, load_rsp;
  logic [ST_W-1:0]     sts_set, sts_q;
  logic [NWORDS*32-1:0] rsp_words;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign widx       = reg_addr[AW-1:2];
  assign unused_lsb = reg_addr[1:0];

  always_comb begin
    cmd_wr     = reg_wen && (widx == IW'(WI_CMD)) && !cmd_new;
    launch     = cmd_wr && reg_wdata[CMD_START];
    arg_en     = reg_wen && (widx == IW'(WI_ARG));
    tout_en    = reg_wen && (widx == IW'(WI_TOUT));
    sts_clr    = reg_wen && (widx == IW'(WI_STS));
    cmd_bits_d = cmd_wr ? (reg_wdata[13:0] & CMD_KEEP_MASK) : cmd_bits;
    cmd_new_d  = cmd_wr ? reg_wdata[CMD_START] : (cmd_new && !finish);
    cmd_fail_d = cmd_wr ? 1'b0 : (cmd_fail || set_fail);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cmd_bits <= '0;
      cmd_new  <= 1'b0;
      cmd_fail <= 1'b0;
      arg_q    <= '0;
      tout_q   <= '0;
    end else begin
      if (cmd_wr)  cmd_bits <= cmd_bits_d;
      cmd_new  <= cmd_new_d;
      cmd_fail <= cmd_fail_d;
      if (arg_en)  arg_q  <= reg_wdata;
      if (tout_en) tout_q <= reg_wdata[TOUT_W-1:0];
    end
  end

  sdh_cmd_seq #(.TOUT_W(TOUT_W)) i_seq (
    .clk(clk), .rst_n(rst_n_s), .launch(launch),
    .no_rsp(cmd_bits[CMD_NORSP]), .busy_wait(cmd_bits[CMD_BUSYW]),
    .tout_lim(tout_q), .ser_ack(ser_ack), .rsp_valid(rsp_valid),
    .rsp_crc_err(rsp_crc_err), .sd_tick(sd_tick), .card_busy(card_busy),
    .ser_req(ser_req), .finish(finish), .set_fail(set_fail),
    .set_tout(set_tout), .set_crc7(set_crc7), .set_busy(set_busy),
    .load_rsp(load_rsp)
  );

  always_comb begin
    sts_set           = '0;
    sts_set[ST_BUSY]  = set_busy;
    sts_set[ST_CTOUT] = set_tout;
    sts_set[ST_CRC7]  = set_crc7;
  end

  sdh_w1c_status #(.W(ST_W), .CLR_LO(ST_CLR_LO), .CLR_HI(ST_CLR_HI)) i_sts (
    .clk(clk), .rst_n(rst_n_s), .set_vec(sts_set), .clr_en(sts_clr),
    .clr_bits(reg_wdata[ST_W-1:0]), .sts(sts_q)
  );

  sdh_rsp_store #(.NWORDS(NWORDS), .WW(32)) i_rsp (
    .clk(clk), .rst_n(rst_n_s), .load(load_rsp), .long_rsp(cmd_bits[CMD_LONG]),
    .rsp_in(rsp_data), .words(rsp_words)
  );

  assign ser_index    = cmd_bits[5:0];
  assign ser_arg      = arg_q;
  assign ser_rsp_none = cmd_bits[CMD_NORSP];
  assign ser_rsp_long = cmd_bits[CMD_LONG];

  always_comb begin
    reg_rdata = '0;
    if (widx == IW'(WI_CMD))  reg_rdata = {16'h0, cmd_new, cmd_fail, cmd_bits};
    if (widx == IW'(WI_ARG))  reg_rdata = arg_q;
    if (widx == IW'(WI_TOUT)) reg_rdata = 32'(tout_q);
    if (widx == IW'(WI_STS))  reg_rdata = 32'(sts_q);
    for (int w = 0; w < NWORDS; w++)
      if (widx == IW'(WI_RSP0 + w)) reg_rdata = rsp_words[w*32 +: 32];
  end
endmodule

// File: rtl/sdh_cmd_chk.sv
module sdh_cmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wen,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        ser_req,
  input logic        cmd_new,
  input logic        cmd_fail,
  input logic [13:0] cmd_bits,
  input logic [10:0] sts_q,
  input logic        finish
);
  logic [10:0] clr_mask;
  assign clr_mask = (reg_wen && reg_addr == 8'h20) ? reg_wdata[10:0] : 11'h0;

  p_req_in_flight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_req |-> cmd_new);

  p_start_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_new && !finish) |=> cmd_new);

  p_locked_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_new && reg_wen && reg_addr == 8'h00) |=> (cmd_bits == $past(cmd_bits)));

  p_w1c_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & $past(sts_q & ~clr_mask)) == $past(sts_q & ~clr_mask)));

  p_fail_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_fail) |-> (sts_q[6] || sts_q[4]));

  p_busy_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[10]) |-> cmd_bits[11]);
endmodule

bind sdh_cmd_regs sdh_cmd_chk i_sdh_cmd_chk (
  .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ser_req(ser_req), .cmd_new(cmd_new),
  .cmd_fail(cmd_fail), .cmd_bits(cmd_bits), .sts_q(sts_q), .finish(finish)
);

// File: tb/test_sdh_cmd_regs.sv
module test_sdh_cmd_regs;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wen = 1'b0;
  logic [7:0]   reg_addr = 8'h0;
  logic [31:0]  reg_wdata = 32'h0;
  logic [31:0]  reg_rdata;
  logic         ser_req, ser_rsp_none, ser_rsp_long;
  logic [5:0]   ser_index;
  logic [31:0]  ser_arg;
  logic         ser_ack = 1'b0, rsp_valid = 1'b0, rsp_crc_err = 1'b0;
  logic [127:0] rsp_data = '0;
  logic         sd_tick = 1'b0, card_busy = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_rsp [4];

  always #2.5 clk = ~clk;

  sdh_cmd_regs i_sdh_cmd_regs (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_req(ser_req),
    .ser_index(ser_index), .ser_arg(ser_arg), .ser_rsp_none(ser_rsp_none),
    .ser_rsp_long(ser_rsp_long), .ser_ack(ser_ack), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_crc_err(rsp_crc_err), .sd_tick(sd_tick),
    .card_busy(card_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ack_cmd(input string req, input logic [5:0] idx, input logic [31:0] arg);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ser_req) break;
    end
    chk(req, {25'h0, ser_req, ser_index}, {25'h0, 1'b1, idx});
    chk(req, ser_arg, arg);
    ser_ack = 1'b1;
    @(negedge clk);
    ser_ack = 1'b0;
  endtask

  task automatic give_rsp(input logic [127:0] d, input logic crc);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = d; rsp_crc_err = crc;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_crc_err = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sd_tick = 1'b1;
    @(negedge clk);
    sd_tick = 1'b0;
  endtask

  task automatic check_words(input string req);
    logic [31:0] d;
    for (int w = 0; w < 4; w++) begin
      rd(8'h10 + 8'(4*w), d);
      chk(req, d, exp_rsp[w]);
    end
  endtask

  function automatic logic [31:0] cmd_view(input logic [31:0] cw, input logic st, input logic fl);
    return {16'h0, st, fl, cw[13:0] & 14'h0EFF};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, cw, arg;
    logic [127:0] r;
    void'($urandom(32'h5D1C));
    for (int w = 0; w < 4; w++) exp_rsp[w] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    foreach (exp_rsp[w]) begin end
    for (int a = 0; a <= 8'h20; a += 4) begin
      rd(8'(a), d);
      chk("R1", d, 32'h0);
    end
    chk("R1", {31'h0, ser_req}, 32'h0);

    // R2 plain read/write words
    wr(8'h04, 32'hA5C3_0F1E); rd(8'h04, d); chk("R2", d, 32'hA5C3_0F1E);
    wr(8'h08, 32'h0001_0000); rd(8'h08, d); chk("R2", d, 32'h0001_0000);
    wr(8'h00, 32'h0000_3FFF); rd(8'h00, d); chk("R2", d, 32'h0000_2EFF & 32'h0EFF);

    // random commands: R3 R5 R6 R7
    for (int it = 0; it < 30; it++) begin
      int mode;
      mode = int'($urandom % 3);
      arg  = $urandom;
      cw   = 32'h8000 | ($urandom & 32'hC0) | ($urandom & 32'h3F);
      if (mode == 0) cw |= 32'h400;
      if (mode == 2) cw |= 32'h200;
      r = {$urandom, $urandom, $urandom, $urandom};
      wr(8'h04, arg);
      wr(8'h00, cw);
      rd(8'h00, d); chk("R3 pending", d, cmd_view(cw, 1'b1, 1'b0));
      ack_cmd("R3", cw[5:0], arg);
      if (mode != 0) begin
        rd(8'h00, d); chk("R3 waits", d, cmd_view(cw, 1'b1, 1'b0));
        give_rsp(r, 1'b0);
        exp_rsp[0] = r[31:0];
        if (mode == 2) begin
          exp_rsp[1] = r[63:32]; exp_rsp[2] = r[95:64]; exp_rsp[3] = r[127:96];
        end
      end
      rd(8'h00, d);
      chk(mode == 0 ? "R5" : "R3 done", d, cmd_view(cw, 1'b0, 1'b0));
      check_words(mode == 2 ? "R7" : "R6");
    end

    // R4 write while active is ignored
    wr(8'h04, 32'h1111_2222);
    cw = 32'h8000 | 32'h400 | 32'd9;
    wr(8'h00, cw);
    wr(8'h00, 32'h8000 | 32'd44);
    rd(8'h00, d); chk("R4", d, cmd_view(cw, 1'b1, 1'b0));
    ack_cmd("R4", 6'd9, 32'h1111_2222);
    rd(8'h00, d); chk("R4", d, cmd_view(cw, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    chk("R4 no relaunch", {31'h0, ser_req}, 32'h0);

    // R8 timeout after 3 ticks
    wr(8'h08, 32'd3);
    cw = 32'h8000 | 32'd17;
    wr(8'h00, cw);
    ack_cmd("R8", 6'd17, 32'h1111_2222);
    tick(); tick();
    rd(8'h00, d); chk("R8 before limit", d, cmd_view(cw, 1'b1, 1'b0));
    tick();
    rd(8'h00, d); chk("R8 fail", d, cmd_view(cw, 1'b0, 1'b1));
    rd(8'h20, d); chk("R8 status", d, 32'h40);

    // R11 write-1-to-clear
    wr(8'h20, 32'h0); rd(8'h20, d); chk("R11 zero write", d, 32'h40);
    wr(8'h20, 32'h40); rd(8'h20, d); chk("R11 clear", d, 32'h0);

    // R12 new command clears fail
    cw = 32'h8000 | 32'h400 | 32'd3;
    wr(8'h00, cw);
    rd(8'h00, d); chk("R12", d, cmd_view(cw, 1'b1, 1'b0));
    ack_cmd("R12", 6'd3, 32'h1111_2222);

    // R9 CRC7 error
    wr(8'h08, 32'd1000);
    cw = 32'h8000 | 32'd41;
    wr(8'h00, cw);
    ack_cmd("R9", 6'd41, 32'h1111_2222);
    give_rsp({96'h0, 32'hDEAD_0042}, 1'b1);
    exp_rsp[0] = 32'hDEAD_0042;
    rd(8'h00, d); chk("R9 fail", d, cmd_view(cw, 1'b0, 1'b1));
    rd(8'h20, d); chk("R9 status", d, 32'h10);
    rd(8'h10, d); chk("R9 word", d, exp_rsp[0]);
    wr(8'h20, 32'h7F8);
    rd(8'h20, d); chk("R11 clear all", d, 32'h0);

    // R10 busy wait
    card_busy = 1'b1;
    cw = 32'h8000 | 32'h800 | 32'd7;
    wr(8'h00, cw);
    ack_cmd("R10", 6'd7, 32'h1111_2222);
    give_rsp({96'h0, 32'h0000_0900}, 1'b0);
    repeat (3) @(negedge clk);
    rd(8'h00, d); chk("R10 held", d, cmd_view(cw, 1'b1, 1'b0));
    rd(8'h20, d); chk("R10 no event yet", d, 32'h0);
    @(negedge clk);
    card_busy = 1'b0;
    rd(8'h00, d); chk("R10 done", d, cmd_view(cw, 1'b0, 1'b0));
    rd(8'h20, d); chk("R10 status", d, 32'h400);
    wr(8'h20, 32'h400); rd(8'h20, d); chk("R11 busy clear", d, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule